// File: doc/BRIEF.md
# Conditional-branch microcode sequencer

The sequencer steps through a built-in micro-program, one micro-word per clock. It holds a micro-program counter and reads the addressed word from an internal ROM. It then picks the next address in one of three ways. In sequential mode it adds either 1 or a word-supplied displacement, and the displacement is taken only when a jump condition on the status flags is true. In dispatch mode it looks the instruction byte up in a 256-entry start-address table. In vector mode it returns to the fetch address, or goes to the interrupt routine when interrupts are enabled and one is pending.

The status flags, the instruction byte and the source-register value are all inputs. They come from a datapath and ALU that live outside the block. The block does not update them itself. Each cycle it sends back four things. The ALU command with its result-write strobe. A flag-commit strobe. A clear strobe for the pending-interrupt register. The value for the internal data bus. A micro-word with the halt bit stops the machine. The halt word performs no action, and the block stays stopped until reset.

Micro-program layout (6-bit addresses):
- Word 0 is the fetch word: sequential, never jumps, immediate 0x11 on the bus.
- Word 1 dispatches.
- Word 8 is the interrupt entry: clear-interrupt, immediate 0xA5, sequential.
- Word 60 halts.
- Routine k (k = 0..7) starts at 16+4k.
- For k < 7, the first word is sequential with criterion k and an immediate on the bus. The displacement is 0x02, except that k = 6 uses 0x18. Its second word is vector mode with ALU SUB, no flag commit. Its third word is vector mode with ALU AND and flag commit.
- Routine 7 starts with a sequential never-jump word with ALU ADD, flag commit, and the bus taken from the source input. Its second word is vector mode with clear-interrupt.
- Every other word is vector mode with no action.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_ni is low, mip_o is 0 and halt_o is 0. After reset is released, execution starts at word 0.
- R2: In sequential mode, if the condition is false or the criterion is "never", mip_o becomes mip_o+1 at the next edge. Word 0 therefore goes to 1 even though its immediate is 0x11.
- R3: Criterion codes are 0 never, 1 sign, 2 overflow, 3 zero, 4 not-sign, 5 not-overflow and 6 not-zero. They are evaluated on the flag inputs of the current cycle. When the condition holds, the next address is the current address plus the immediate, modulo 64. For example, 40+0x18 wraps to 0.
- R4: In dispatch mode, the next address is 60 when bits 7:6 of ir_i are both 1. Otherwise it is 16+4·ir_i[2:0].
- R5: In vector mode, the next address is 8 when irq_en_i and irq_pend_i are both 1. Otherwise it is 0.
- R6: bus_o equals the word's immediate when the word's immediate-enable bit is set. Otherwise it equals src_data_i.
- R7: irq_clr_o is 1 in the cycle that executes a word with the clear-interrupt bit set.
- R8: alu_cmd_o carries the word's command (0 NOP, 1 ADD, 2 SUB, 3 AND). res_we_o is 1 exactly when that command is not NOP.
- R9: flag_we_o is 1 only when the command is not NOP and the word's flag-commit bit is set.
- R10: A word with the halt bit drives halt_o high in the same cycle. From then until reset, mip_o does not change, and alu_cmd_o, res_we_o, flag_we_o and irq_clr_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 8 | Instruction register value for dispatch |
| flag_sign_i | input | 1 | Sign status flag |
| flag_ovf_i | input | 1 | Overflow status flag |
| flag_zero_i | input | 1 | Zero status flag |
| irq_en_i | input | 1 | Interrupt-enable status bit |
| irq_pend_i | input | 1 | Pending-interrupt register |
| src_data_i | input | 8 | Selected source register value |
| mip_o | output | 6 | Current micro-program address |
| alu_cmd_o | output | 4 | ALU command for this step |
| res_we_o | output | 1 | Result register write strobe |
| flag_we_o | output | 1 | Status flag commit strobe |
| irq_clr_o | output | 1 | Clear pending-interrupt strobe |
| bus_o | output | 8 | Data bus value |
| halt_o | output | 1 | Sequencer halted |

## Verification
A wrong next address shows on mip_o one edge after the step that computed it. A wrong ROM or table entry then pushes every later step off the expected path. Each step is therefore compared with its expected address, so a bad jump, dispatch or vector choice is caught in the cycle after it happens. The strobes and bus_o depend only on the current word, and they are checked in the same cycle that word is held. A halt that fails to stick shows as a change on mip_o at the very next edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned MIP_W      = 6;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned OP_W       = 8;
  localparam int unsigned CMD_W      = 4;
  localparam int unsigned ROM_DEPTH  = 1 << MIP_W;
  localparam int unsigned OP_CNT     = 1 << OP_W;
  localparam int unsigned RTN_BASE   = 16;
  localparam int unsigned RTN_STRIDE = 4;
  localparam int unsigned RTN_CNT    = 8;

  localparam logic [MIP_W-1:0] FETCH_VEC = MIP_W'(0);
  localparam logic [MIP_W-1:0] IRQ_VEC   = MIP_W'(8);
  localparam logic [MIP_W-1:0] HALT_VEC  = MIP_W'(60);

  localparam logic [CMD_W-1:0] ALU_NOP = CMD_W'(0);
  localparam logic [CMD_W-1:0] ALU_ADD = CMD_W'(1);
  localparam logic [CMD_W-1:0] ALU_SUB = CMD_W'(2);
  localparam logic [CMD_W-1:0] ALU_AND = CMD_W'(3);

  typedef enum logic [1:0] {NA_SEQ, NA_MAP, NA_VEC, NA_RSV} nxt_mode_e;
  typedef enum logic [2:0] {JC_NEVER, JC_NEG, JC_OVF, JC_ZER,
                            JC_POS, JC_NOVF, JC_NZER, JC_RSV} jcrit_e;

  typedef struct packed {
    logic              halt;
    logic              clr_irq;
    logic              aff;
    logic [CMD_W-1:0]  alu;
    logic              imm_en;
    logic [DATA_W-1:0] imm;
    jcrit_e            crit;
    nxt_mode_e         mode;
  } uword_t;

  function automatic uword_t ucode_word(int unsigned a);
    uword_t w;
    int unsigned k, slot;
    w = '0;
    w.mode = NA_VEC;
    if (a == 0) begin
      w.mode = NA_SEQ; w.imm_en = 1'b1; w.imm = DATA_W'(8'h11);
    end else if (a == 1) begin
      w.mode = NA_MAP;
    end else if (a == int'(IRQ_VEC)) begin
      w.mode = NA_SEQ; w.clr_irq = 1'b1; w.imm_en = 1'b1; w.imm = DATA_W'(8'hA5);
    end else if (a == int'(HALT_VEC)) begin
      w.mode = NA_SEQ; w.halt = 1'b1;
    end else if (a >= RTN_BASE && a < RTN_BASE + RTN_STRIDE * RTN_CNT) begin
      k    = (a - RTN_BASE) / RTN_STRIDE;
      slot = (a - RTN_BASE) % RTN_STRIDE;
      if (slot == 0) begin
        w.mode = NA_SEQ;
        if (k == RTN_CNT - 1) begin
          w.alu = ALU_ADD; w.aff = 1'b1; w.imm = DATA_W'(8'h02);
        end else begin
          w.crit   = jcrit_e'(3'(k));
          w.imm_en = 1'b1;
          w.imm    = (k == 6) ? DATA_W'(8'h18) : DATA_W'(8'h02);
        end
      end else if (slot == 1) begin
        if (k == RTN_CNT - 1) w.clr_irq = 1'b1;
        else                  w.alu = ALU_SUB;
      end else if (slot == 2) begin
        w.alu = ALU_AND; w.aff = 1'b1;
      end
    end
    return w;
  endfunction

  function automatic logic [MIP_W-1:0] op_entry(int unsigned op);
    if (((op >> (OP_W - 2)) & 3) == 3) return HALT_VEC;
    return MIP_W'(RTN_BASE + RTN_STRIDE * (op % RTN_CNT));
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [MIP_W-1:0] addr_i,
  output uword_t           word_o
);
  uword_t rom [ROM_DEPTH];

  for (genvar a = 0; a < ROM_DEPTH; a++) begin : g_rom
    assign rom[a] = ucode_word(a);
  end

  assign word_o = rom[addr_i];
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  output logic [MIP_W-1:0] entry_o
);
  logic [MIP_W-1:0] map [OP_CNT];

  for (genvar o = 0; o < OP_CNT; o++) begin : g_map
    assign map[o] = op_entry(o);
  end

  assign entry_o = map[op_i];
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  jcrit_e crit_i,
  input  logic   sign_i,
  input  logic   ovf_i,
  input  logic   zero_i,
  output logic   taken_o
);
  always_comb begin
    case (crit_i)
      JC_NEG:  taken_o = sign_i;
      JC_OVF:  taken_o = ovf_i;
      JC_ZER:  taken_o = zero_i;
      JC_POS:  taken_o = !sign_i;
      JC_NOVF: taken_o = !ovf_i;
      JC_NZER: taken_o = !zero_i;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   ir_i,
  input  logic              flag_sign_i,
  input  logic              flag_ovf_i,
  input  logic              flag_zero_i,
  input  logic              irq_en_i,
  input  logic              irq_pend_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [MIP_W-1:0]  mip_o,
  output logic [CMD_W-1:0]  alu_cmd_o,
  output logic              res_we_o,
  output logic              flag_we_o,
  output logic              irq_clr_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              halt_o
);
  logic [MIP_W-1:0] mip_q, mip_d, map_addr;
  logic             halted_q, taken, active;
  uword_t           uw;

  useq_rom u_rom (.addr_i(mip_q), .word_o(uw));

  useq_decode u_decode (.op_i(ir_i), .entry_o(map_addr));

  useq_cond u_cond (
    .crit_i (uw.crit),
    .sign_i (flag_sign_i),
    .ovf_i  (flag_ovf_i),
    .zero_i (flag_zero_i),
    .taken_o(taken)
  );

  // halt word itself performs no action
  assign active = !(halted_q || uw.halt);

  always_comb begin
    case (uw.mode)
      NA_MAP:  mip_d = map_addr;
      NA_VEC:  mip_d = (irq_en_i && irq_pend_i) ? IRQ_VEC : FETCH_VEC;
      default: mip_d = mip_q + (taken ? MIP_W'(uw.imm) : MIP_W'(1));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mip_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (uw.halt) halted_q <= 1'b1;
      if (active)  mip_q    <= mip_d;
    end
  end

  assign mip_o     = mip_q;
  assign halt_o    = !active;
  assign alu_cmd_o = active ? uw.alu : ALU_NOP;
  assign res_we_o  = active && (uw.alu != ALU_NOP);
  assign flag_we_o = res_we_o && uw.aff;
  assign irq_clr_o = active && uw.clr_irq;
  assign bus_o     = uw.imm_en ? uw.imm : src_data_i;

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && uw.mode == NA_SEQ && !taken) |=> (mip_q == $past(mip_q) + MIP_W'(1))); // R2
  AST_NEVER_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uw.crit == JC_NEVER) |-> !taken); // R3
  AST_MAP_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && uw.mode == NA_MAP && ir_i[OP_W-1 -: 2] == 2'b11) |=> halt_o); // R4
  AST_VEC_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && uw.mode == NA_VEC) |=> (mip_q == FETCH_VEC || mip_q == IRQ_VEC)); // R5
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && $stable(mip_q))); // R10
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !(res_we_o || flag_we_o || irq_clr_o)); // R10
endmodule

// File: tb/useq_sequencer_test.sv
`timescale 1ns/1ps
module useq_sequencer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ir_i = '0;
  logic       flag_sign_i = 1'b0, flag_ovf_i = 1'b0, flag_zero_i = 1'b0;
  logic       irq_en_i = 1'b0, irq_pend_i = 1'b0;
  logic [7:0] src_data_i = '0;
  logic [5:0] mip_o;
  logic [3:0] alu_cmd_o;
  logic       res_we_o, flag_we_o, irq_clr_o, halt_o;
  logic [7:0] bus_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = !clk_i;

  useq_sequencer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i),
    .flag_sign_i(flag_sign_i), .flag_ovf_i(flag_ovf_i), .flag_zero_i(flag_zero_i),
    .irq_en_i(irq_en_i), .irq_pend_i(irq_pend_i), .src_data_i(src_data_i),
    .mip_o(mip_o), .alu_cmd_o(alu_cmd_o), .res_we_o(res_we_o),
    .flag_we_o(flag_we_o), .irq_clr_o(irq_clr_o), .bus_o(bus_o), .halt_o(halt_o)
  );

  // {ir, sign ovf zero, dispatch base, jump target, address after target}
  localparam logic [28:0] VECS [15] = '{
    {8'h00, 3'b000, 6'd16, 6'd17, 6'd0},
    {8'h01, 3'b100, 6'd20, 6'd22, 6'd0},
    {8'h09, 3'b000, 6'd20, 6'd21, 6'd0},
    {8'h02, 3'b010, 6'd24, 6'd26, 6'd0},
    {8'h0A, 3'b000, 6'd24, 6'd25, 6'd0},
    {8'h03, 3'b001, 6'd28, 6'd30, 6'd0},
    {8'h03, 3'b110, 6'd28, 6'd29, 6'd0},
    {8'h04, 3'b000, 6'd32, 6'd34, 6'd0},
    {8'h04, 3'b100, 6'd32, 6'd33, 6'd0},
    {8'h05, 3'b000, 6'd36, 6'd38, 6'd0},
    {8'h05, 3'b011, 6'd36, 6'd37, 6'd0},
    {8'h06, 3'b000, 6'd40, 6'd0,  6'd1},
    {8'h06, 3'b001, 6'd40, 6'd41, 6'd0},
    {8'h07, 3'b111, 6'd44, 6'd45, 6'd0},
    {8'h80, 3'b000, 6'd16, 6'd17, 6'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    #0.5;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 mip in reset", int'(mip_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
    chk("R1 mip after reset", int'(mip_o), 0);
    chk("R1 halt after reset", int'(halt_o), 0);
    chk("R8 no write at fetch", int'(res_we_o), 0);
    chk("R6 fetch immediate", int'(bus_o), 8'h11);

    for (int i = 0; i < 15; i++) begin
      do_reset();
      ir_i        = VECS[i][28:21];
      flag_sign_i = VECS[i][20];
      flag_ovf_i  = VECS[i][19];
      flag_zero_i = VECS[i][18];
      #0.5;
      step();
      chk("R2 sequential step", int'(mip_o), 1);
      step();
      chk("R4 dispatch entry", int'(mip_o), int'(VECS[i][17:12]));
      step();
      chk("R3 jump outcome", int'(mip_o), int'(VECS[i][11:6]));
      step();
      chk("R5 return address", int'(mip_o), int'(VECS[i][5:0]));
    end

    // directed: ALU strobes, bus source, interrupt vectoring
    do_reset();
    ir_i = 8'h07; src_data_i = 8'h3C;
    flag_sign_i = 1'b0; flag_ovf_i = 1'b0; flag_zero_i = 1'b0;
    step(); step();
    chk("R8 add command", int'(alu_cmd_o), 1);
    chk("R8 result write", int'(res_we_o), 1);
    chk("R9 flag commit", int'(flag_we_o), 1);
    chk("R6 bus from source", int'(bus_o), 8'h3C);
    step();
    chk("R7 clear strobe", int'(irq_clr_o), 1);
    chk("R8 nop no write", int'(res_we_o), 0);
    irq_en_i = 1'b1; irq_pend_i = 1'b1;
    step();
    chk("R5 interrupt vector", int'(mip_o), 8);
    chk("R7 clear in irq entry", int'(irq_clr_o), 1);
    chk("R6 irq immediate", int'(bus_o), 8'hA5);
    step();
    irq_pend_i = 1'b0;
    step();
    chk("R5 enabled but none pending", int'(mip_o), 0);
    ir_i = 8'h09; flag_sign_i = 1'b0;
    step(); step(); step();
    chk("R3 sign not set falls through", int'(mip_o), 21);
    chk("R8 sub command", int'(alu_cmd_o), 2);
    chk("R8 sub writes result", int'(res_we_o), 1);
    chk("R9 no flag commit", int'(flag_we_o), 0);
    irq_en_i = 1'b0; irq_pend_i = 1'b1;
    step();
    chk("R5 pending but disabled", int'(mip_o), 0);

    // directed: sticky halt
    irq_pend_i = 1'b0;
    do_reset();
    ir_i = 8'hC5;
    step();
    chk("R10 not halted before", int'(halt_o), 0);
    step();
    chk("R4 halt opcode entry", int'(mip_o), 60);
    chk("R10 halt same cycle", int'(halt_o), 1);
    chk("R10 no clear strobe", int'(irq_clr_o), 0);
    irq_en_i = 1'b1; irq_pend_i = 1'b1;
    step(); step(); step();
    chk("R10 mip frozen", int'(mip_o), 60);
    chk("R10 still halted", int'(halt_o), 1);
    chk("R10 no result write", int'(res_we_o), 0);
    chk("R10 no alu command", int'(alu_cmd_o), 0);
    do_reset();
    chk("R1 reset leaves halt", int'(halt_o), 0);
    chk("R1 reset restarts", int'(mip_o), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule